// File: doc/BRIEF.md
# DMA Controller Register Interface

This block is the slave-side register front end of a multi-channel DMA controller. It occupies a 4 KB word-addressed window and decodes each request into one of three regions: a small set of global words near the base, a window of per-channel register banks, and a run of identification bytes at the top of the window. It stores the channel banks and the global configuration and sync words itself. It produces one-cycle clear strobes for the interrupt unit and a one-cycle re-evaluation pulse for the transfer engine, which is built elsewhere.

Requests arrive as a single-cycle strobe with a write flag, a byte offset and write data. Read data, the invalid-access flag and every strobe are registered. They appear on the clock edge that samples the request and last one cycle. The channel count is a parameter, 2 or 8. It sets how many banks exist and which identification byte is reported first.

Top module: `dma_regif`

## Requirements
- R1: After reset every stored word (channel banks, global configuration, sync) is zero, and all outputs are zero.
- R2: Offsets 0x100 to 0x1FF hold the channel banks. The channel index is offset bits 7:5. Inside a 32-byte bank the words are source 0x00, destination 0x04, link pointer 0x08, control 0x0C and configuration 0x10. A write stores the data, and a read returns the stored word.
- R3: An access to a channel index at or above the channel count, or to bank word 0x14, 0x18 or 0x1C, is invalid.
- R4: The global configuration word at 0x30 and the sync word at 0x34 are readable and writable. Outside a write to them, they hold their value.
- R5: The re-evaluation output pulses for one cycle after a write to any bank configuration word (bank offset 0x10) or to 0x30, and at no other time.
- R6: A write to 0x08 pulses the TC clear output for one cycle, carrying write data bits NCH-1:0. A write to 0x10 does the same on the error clear output. Both offsets are write-only, so a read of either is invalid.
- R7: Reads return the interrupt unit inputs zero-extended, as follows:
  - 0x00 returns TC status OR error status.
  - 0x04 returns TC status.
  - 0x0C returns error status.
  - 0x14 returns raw TC.
  - 0x18 returns raw error.
  These offsets are read-only, so a write to them is invalid and has no effect.
- R8: A read of 0x1C returns bit 0 of channel i's configuration word at bit i, with all other bits zero.
- R9: Offsets 0x20, 0x24, 0x28 and 0x2C are valid. They read as zero, and writes to them change nothing.
- R10: A read at 0xFE0 + 4k (k = 0..7) returns one byte, zero-extended, from this list: 0x80 for an 8-channel build or 0x81 otherwise, then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1. A write there is invalid.
- R11: An invalid access returns read data zero, raises the invalid flag for exactly that one cycle, and changes no stored word. Besides the cases above, the invalid offsets are 0x38 to 0xFF and 0x200 to 0xFDF.
- R12: In a cycle with no request, read data is zero and no flag or strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the 4 KB window |
| req_wdata | input | 32 | Write data |
| tc_stat_i | input | NCH | Masked TC status from the interrupt unit |
| tc_raw_i | input | NCH | Raw TC status |
| err_stat_i | input | NCH | Masked error status |
| err_raw_i | input | NCH | Raw error status |
| rd_data | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle invalid-access flag |
| reeval | output | 1 | One-cycle re-evaluate pulse to the engine |
| tc_clear | output | NCH | One-cycle TC clear bits |
| err_clear | output | NCH | One-cycle error clear bits |
| glob_cfg | output | 32 | Global configuration word |
| glob_sync | output | 32 | Sync word |
| ch_src | output | NCH*32 | Source words, channel i at bits 32i+31:32i |
| ch_dst | output | NCH*32 | Destination words |
| ch_link | output | NCH*32 | Link pointer words |
| ch_ctl | output | NCH*32 | Control words |
| ch_cfg | output | NCH*32 | Configuration words |

## Verification
Every result of a request is due on the one clock edge that samples it: read data, the invalid flag, the clear strobes, the re-evaluation pulse and the updated stored words. The bench drives each request on a falling edge. It then checks all outputs just after the next rising edge against a behavioural model, which has advanced by that same single request. Because every cycle is compared, a strobe that lasts two cycles or arrives a cycle late fails in the following cycle, where the model expects zero.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_GLOB = 2'd1,
        RG_CHAN = 2'd2,
        RG_ID   = 2'd3
    } region_e;

    typedef struct packed {
        region_e     region;
        logic [2:0]  chan;
        logic [3:0]  word;
        logic        ok;
    } dec_t;

    // global word numbers (offset / 4)
    localparam logic [3:0] GW_ALL   = 4'd0;
    localparam logic [3:0] GW_TCST  = 4'd1;
    localparam logic [3:0] GW_TCCLR = 4'd2;
    localparam logic [3:0] GW_ERST  = 4'd3;
    localparam logic [3:0] GW_ERCLR = 4'd4;
    localparam logic [3:0] GW_TCRAW = 4'd5;
    localparam logic [3:0] GW_ERRAW = 4'd6;
    localparam logic [3:0] GW_ENA   = 4'd7;
    localparam logic [3:0] GW_CFG   = 4'd12;
    localparam logic [3:0] GW_SYNC  = 4'd13;

    // bank word numbers
    localparam logic [3:0] CW_SRC = 4'd0;
    localparam logic [3:0] CW_DST = 4'd1;
    localparam logic [3:0] CW_LNK = 4'd2;
    localparam logic [3:0] CW_CTL = 4'd3;
    localparam logic [3:0] CW_CFG = 4'd4;

    function automatic logic [7:0] id_byte(input logic [2:0] k, input int nch);
        case (k)
            3'd0:    id_byte = (nch == 8) ? 8'h80 : 8'h81;
            3'd1:    id_byte = 8'h10;
            3'd2:    id_byte = 8'h04;
            3'd3:    id_byte = 8'h0A;
            3'd4:    id_byte = 8'h0D;
            3'd5:    id_byte = 8'hF0;
            3'd6:    id_byte = 8'h05;
            default: id_byte = 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dma_regif_decode.sv
module dma_regif_decode
    import dma_regif_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic [11:0] addr,
    input  logic        write,
    output dec_t        dec
);

    always_comb begin
        dec        = '0;
        dec.region = RG_NONE;
        if (addr[11:8] == 4'h1) begin
            dec.region = RG_CHAN;
            dec.chan   = addr[7:5];
            dec.word   = {1'b0, addr[4:2]};
            dec.ok     = (32'(addr[7:5]) < NCH) && ({1'b0, addr[4:2]} <= CW_CFG);
        end else if (addr >= 12'hFE0) begin
            dec.region = RG_ID;
            dec.word   = {1'b0, addr[4:2]};
            dec.ok     = !write;
        end else if ((addr[11:6] == 6'd0) && (addr[5:2] <= GW_SYNC)) begin
            dec.region = RG_GLOB;
            dec.word   = addr[5:2];
            if (write)
                dec.ok = (addr[5:2] == GW_TCCLR) || (addr[5:2] == GW_ERCLR) ||
                         (addr[5:2] >= 4'd8);
            else
                dec.ok = (addr[5:2] != GW_TCCLR) && (addr[5:2] != GW_ERCLR);
        end
    end

endmodule

// File: rtl/dma_regif_chbank.sv
module dma_regif_chbank
    import dma_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [3:0]  word,
    input  logic [31:0] wdata,
    output logic [31:0] src,
    output logic [31:0] dst,
    output logic [31:0] lnk,
    output logic [31:0] ctl,
    output logic [31:0] cfg
);

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] lnk;
        logic [31:0] ctl;
        logic [31:0] cfg;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            case (word)
                CW_SRC:  bank_d.src = wdata;
                CW_DST:  bank_d.dst = wdata;
                CW_LNK:  bank_d.lnk = wdata;
                CW_CTL:  bank_d.ctl = wdata;
                CW_CFG:  bank_d.cfg = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign src = bank_q.src;
    assign dst = bank_q.dst;
    assign lnk = bank_q.lnk;
    assign ctl = bank_q.ctl;
    assign cfg = bank_q.cfg;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(bank_q)); // R2

endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [11:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [NCH-1:0]    tc_stat_i,
    input  logic [NCH-1:0]    tc_raw_i,
    input  logic [NCH-1:0]    err_stat_i,
    input  logic [NCH-1:0]    err_raw_i,
    output logic [31:0]       rd_data,
    output logic              bad_access,
    output logic              reeval,
    output logic [NCH-1:0]    tc_clear,
    output logic [NCH-1:0]    err_clear,
    output logic [31:0]       glob_cfg,
    output logic [31:0]       glob_sync,
    output logic [NCH*32-1:0] ch_src,
    output logic [NCH*32-1:0] ch_dst,
    output logic [NCH*32-1:0] ch_link,
    output logic [NCH*32-1:0] ch_ctl,
    output logic [NCH*32-1:0] ch_cfg
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [31:0]    rdata;
        logic           bad;
        logic           reeval;
        logic [NCH-1:0] tcclr;
        logic [NCH-1:0] erclr;
        logic [31:0]    gcfg;
        logic [31:0]    sync;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;

    logic [31:0] src_w [NCH];
    logic [31:0] dst_w [NCH];
    logic [31:0] lnk_w [NCH];
    logic [31:0] ctl_w [NCH];
    logic [31:0] cfg_w [NCH];
    logic [31:0] rd_val;
    logic [31:0] ena_w;

    dma_regif_decode #(.NCH(NCH)) u_dec (
        .addr  (req_addr),
        .write (req_write),
        .dec   (dec)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_bank
        logic we_i;
        assign we_i = req_valid && req_write && dec.ok &&
                      (dec.region == RG_CHAN) && (dec.chan == 3'(i));
        dma_regif_chbank u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (we_i),
            .word  (dec.word),
            .wdata (req_wdata),
            .src   (src_w[i]),
            .dst   (dst_w[i]),
            .lnk   (lnk_w[i]),
            .ctl   (ctl_w[i]),
            .cfg   (cfg_w[i])
        );
        assign ch_src [i*32 +: 32] = src_w[i];
        assign ch_dst [i*32 +: 32] = dst_w[i];
        assign ch_link[i*32 +: 32] = lnk_w[i];
        assign ch_ctl [i*32 +: 32] = ctl_w[i];
        assign ch_cfg [i*32 +: 32] = cfg_w[i];
        assign ena_w[i] = cfg_w[i][0];
    end
    if (NCH < 32) begin : g_ena_pad
        assign ena_w[31:NCH] = '0;
    end

    // read multiplexer
    always_comb begin
        rd_val = '0;
        case (dec.region)
            RG_CHAN: begin
                case (dec.word)
                    CW_SRC:  rd_val = src_w[dec.chan[IW-1:0]];
                    CW_DST:  rd_val = dst_w[dec.chan[IW-1:0]];
                    CW_LNK:  rd_val = lnk_w[dec.chan[IW-1:0]];
                    CW_CTL:  rd_val = ctl_w[dec.chan[IW-1:0]];
                    CW_CFG:  rd_val = cfg_w[dec.chan[IW-1:0]];
                    default: rd_val = '0;
                endcase
            end
            RG_ID:   rd_val = {24'd0, id_byte(dec.word[2:0], NCH)};
            RG_GLOB: begin
                case (dec.word)
                    GW_ALL:   rd_val = 32'(tc_stat_i | err_stat_i);
                    GW_TCST:  rd_val = 32'(tc_stat_i);
                    GW_ERST:  rd_val = 32'(err_stat_i);
                    GW_TCRAW: rd_val = 32'(tc_raw_i);
                    GW_ERRAW: rd_val = 32'(err_raw_i);
                    GW_ENA:   rd_val = ena_w;
                    GW_CFG:   rd_val = st_q.gcfg;
                    GW_SYNC:  rd_val = st_q.sync;
                    default:  rd_val = '0;
                endcase
            end
            default: rd_val = '0;
        endcase
    end

    always_comb begin
        st_d        = st_q;
        st_d.rdata  = '0;
        st_d.bad    = 1'b0;
        st_d.reeval = 1'b0;
        st_d.tcclr  = '0;
        st_d.erclr  = '0;
        if (req_valid) begin
            if (!dec.ok) begin
                st_d.bad = 1'b1;
            end else if (req_write) begin
                if (dec.region == RG_CHAN) begin
                    st_d.reeval = (dec.word == CW_CFG);
                end else if (dec.region == RG_GLOB) begin
                    case (dec.word)
                        GW_TCCLR: st_d.tcclr = req_wdata[NCH-1:0];
                        GW_ERCLR: st_d.erclr = req_wdata[NCH-1:0];
                        GW_CFG: begin
                            st_d.gcfg   = req_wdata;
                            st_d.reeval = 1'b1;
                        end
                        GW_SYNC:  st_d.sync = req_wdata;
                        default:  ;
                    endcase
                end
            end else begin
                st_d.rdata = rd_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data    = st_q.rdata;
    assign bad_access = st_q.bad;
    assign reeval     = st_q.reeval;
    assign tc_clear   = st_q.tcclr;
    assign err_clear  = st_q.erclr;
    assign glob_cfg   = st_q.gcfg;
    assign glob_sync  = st_q.sync;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (rd_data == '0 && !bad_access && !reeval)); // R12
    AST_REEVAL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reeval |-> $past(req_valid && req_write)); // R5
    AST_CLEAR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tc_clear) || (|err_clear)) |-> $past(req_valid && req_write)); // R6
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(glob_cfg) && $stable(glob_sync)); // R4
    AST_BAD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> (rd_data == '0 && !reeval)); // R11

endmodule

// File: tb/tb_dma_regif.sv
`timescale 1ns/1ps
module tb_dma_regif;

    localparam int NCH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [NCH-1:0]    tcs = '0, tcr = '0, ers = '0, err = '0;
    logic [31:0]       rd_data;
    logic              bad_access, reeval;
    logic [NCH-1:0]    tc_clear, err_clear;
    logic [31:0]       glob_cfg, glob_sync;
    logic [NCH*32-1:0] ch_src, ch_dst, ch_link, ch_ctl, ch_cfg;

    int checks = 0;
    int fails  = 0;

    // behavioural model state
    logic [31:0] m_ch [NCH][5];
    logic [31:0] m_cfg = '0, m_sync = '0;

    always #2 clk = ~clk;

    dma_regif #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .tc_stat_i(tcs), .tc_raw_i(tcr), .err_stat_i(ers), .err_raw_i(err),
        .rd_data(rd_data), .bad_access(bad_access), .reeval(reeval),
        .tc_clear(tc_clear), .err_clear(err_clear),
        .glob_cfg(glob_cfg), .glob_sync(glob_sync),
        .ch_src(ch_src), .ch_dst(ch_dst), .ch_link(ch_link),
        .ch_ctl(ch_ctl), .ch_cfg(ch_cfg)
    );

    function automatic logic [7:0] exp_id(input int k);
        logic [7:0] t [8];
        t = '{8'h81, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (k == 0 && NCH == 8) return 8'h80;
        return t[k];
    endfunction

    task automatic compare(input string tag, input logic [31:0] e_rd, input logic e_bad,
                           input logic e_re, input logic [NCH-1:0] e_tc,
                           input logic [NCH-1:0] e_er);
        logic [NCH*32-1:0] e_cfgs, e_srcs;
        for (int c = 0; c < NCH; c++) begin
            e_cfgs[c*32 +: 32] = m_ch[c][4];
            e_srcs[c*32 +: 32] = m_ch[c][0];
        end
        checks++;
        if (rd_data !== e_rd || bad_access !== e_bad || reeval !== e_re ||
            tc_clear !== e_tc || err_clear !== e_er || glob_cfg !== m_cfg ||
            glob_sync !== m_sync || ch_cfg !== e_cfgs || ch_src !== e_srcs) begin
            fails++;
            $display("FAIL %s: got rd=%h bad=%b re=%b tc=%b er=%b cfg=%h sync=%h chcfg=%h chsrc=%h; exp rd=%h bad=%b re=%b tc=%b er=%b cfg=%h sync=%h chcfg=%h chsrc=%h",
                     tag, rd_data, bad_access, reeval, tc_clear, err_clear, glob_cfg,
                     glob_sync, ch_cfg, ch_src, e_rd, e_bad, e_re, e_tc, e_er,
                     m_cfg, m_sync, e_cfgs, e_srcs);
        end
    endtask

    task automatic cyc(input logic v, input logic w, input logic [11:0] a12,
                       input logic [31:0] wd, input string tag);
        logic [31:0]    e_rd = '0;
        logic           e_bad = 1'b0, e_re = 1'b0;
        logic [NCH-1:0] e_tc = '0, e_er = '0;
        int a = int'(a12);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a12; req_wdata = wd;
        if (v) begin
            if (a >= 256 && a < 512) begin
                int c = (a - 256) / 32;
                int k = (a % 32) / 4;
                if (c >= NCH || k > 4) e_bad = 1'b1;
                else if (w) begin m_ch[c][k] = wd; e_re = (k == 4); end
                else e_rd = m_ch[c][k];
            end else if (a >= 4064) begin
                if (w) e_bad = 1'b1;
                else   e_rd = {24'd0, exp_id((a - 4064) / 4)};
            end else if (a < 56) begin
                int g = a / 4;
                if (w) begin
                    case (g)
                        2:  e_tc = wd[NCH-1:0];
                        4:  e_er = wd[NCH-1:0];
                        8, 9, 10, 11: ;
                        12: begin m_cfg = wd; e_re = 1'b1; end
                        13: m_sync = wd;
                        default: e_bad = 1'b1;
                    endcase
                end else begin
                    case (g)
                        0:  e_rd = 32'(tcs | ers);
                        1:  e_rd = 32'(tcs);
                        3:  e_rd = 32'(ers);
                        5:  e_rd = 32'(tcr);
                        6:  e_rd = 32'(err);
                        7:  for (int c = 0; c < NCH; c++) e_rd[c] = m_ch[c][4][0];
                        8, 9, 10, 11: e_rd = '0;
                        12: e_rd = m_cfg;
                        13: e_rd = m_sync;
                        default: e_bad = 1'b1;
                    endcase
                end
            end else begin
                e_bad = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        compare(tag, e_rd, e_bad, e_re, e_tc, e_er);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 5; k++) m_ch[c][k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        compare("R1 reset", '0, 1'b0, 1'b0, '0, '0);
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 5; k++)
                cyc(1, 0, 12'(256 + c*32 + k*4), '0, "R1 reset read");

        // fill banks (config write pulses re-evaluation)
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 5; k++)
                cyc(1, 1, 12'(256 + c*32 + k*4),
                    32'hA500_0000 | 32'(c << 8) | 32'(k << 4) | ((k == 4 && c == 1) ? 32'd1 : 32'd0),
                    (k == 4) ? "R5 bank cfg write" : "R2 bank write");
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 5; k++)
                cyc(1, 0, 12'(256 + c*32 + k*4), '0, "R2 bank read");
        cyc(0, 0, 12'h100, 32'hFFFF_FFFF, "R12 idle");
        cyc(0, 1, 12'h030, 32'hFFFF_FFFF, "R12 idle write flag");

        // invalid bank words and channels
        for (int k = 5; k < 8; k++) begin
            cyc(1, 1, 12'(256 + k*4), 32'hDEAD_BEEF, "R3 bank word write");
            cyc(1, 0, 12'(256 + k*4), '0, "R3 bank word read");
        end
        for (int c = NCH; c < 8; c++) begin
            cyc(1, 1, 12'(256 + c*32 + 16), 32'hFFFF_FFFF, "R3 channel range write");
            cyc(1, 0, 12'(256 + c*32), '0, "R3 channel range read");
        end
        cyc(1, 0, 12'h110, '0, "R11 bank unchanged");

        // global config and sync
        cyc(1, 1, 12'h030, 32'h0000_0001, "R4 R5 cfg write");
        cyc(1, 1, 12'h034, 32'h1234_5678, "R4 sync write");
        cyc(1, 0, 12'h030, '0, "R4 cfg read");
        cyc(1, 0, 12'h034, '0, "R4 sync read");
        cyc(1, 1, 12'h030, 32'hC0DE_0006, "R5 cfg rewrite");
        cyc(1, 1, 12'h10C, 32'h0000_0FFF, "R5 no pulse on control write");

        // clear strobes
        cyc(1, 1, 12'h008, 32'hFFFF_FFFE, "R6 tc clear");
        cyc(1, 1, 12'h010, 32'h0000_0003, "R6 err clear");
        cyc(1, 1, 12'h008, 32'h0000_0003, "R6 tc clear both");
        cyc(1, 0, 12'h008, '0, "R6 tc clear read");
        cyc(1, 0, 12'h010, '0, "R6 err clear read");

        // status words
        tcs = 2'b01; ers = 2'b10; tcr = 2'b11; err = 2'b10;
        for (int g = 0; g < 8; g++) cyc(1, 0, 12'(g*4), '0, "R7 status read");
        tcs = 2'b10; ers = 2'b00; tcr = 2'b10; err = 2'b01;
        cyc(1, 0, 12'h000, '0, "R7 combined");
        cyc(1, 0, 12'h014, '0, "R7 raw tc");
        cyc(1, 0, 12'h018, '0, "R7 raw err");
        cyc(1, 1, 12'h000, 32'hFFFF_FFFF, "R7 status write");
        cyc(1, 1, 12'h01C, 32'hFFFF_FFFF, "R7 enable write");
        cyc(1, 0, 12'h01C, '0, "R8 enable after ignored write");

        // enabled channels
        cyc(1, 1, 12'h110, 32'h0000_0001, "R8 ch0 enable");
        cyc(1, 0, 12'h01C, '0, "R8 both enabled");
        cyc(1, 1, 12'h130, 32'h8000_0000, "R8 ch1 disable");
        cyc(1, 0, 12'h01C, '0, "R8 ch0 only");

        // software request words
        for (int g = 8; g < 12; g++) begin
            cyc(1, 1, 12'(g*4), 32'hFFFF_FFFF, "R9 swreq write");
            cyc(1, 0, 12'(g*4), '0, "R9 swreq read");
        end

        // identification bytes
        for (int k = 0; k < 8; k++) cyc(1, 0, 12'(4064 + k*4), '0, "R10 id read");
        cyc(1, 1, 12'hFE0, 32'h55, "R10 id write");

        // other invalid offsets
        cyc(1, 0, 12'h038, '0, "R11 gap read");
        cyc(1, 1, 12'h0FC, 32'h1, "R11 gap write");
        cyc(1, 1, 12'h200, 32'h1, "R11 mid write");
        cyc(1, 0, 12'hFDC, '0, "R11 mid read");
        cyc(1, 0, 12'h030, '0, "R11 cfg unchanged");
        cyc(1, 0, 12'h034, '0, "R11 sync unchanged");
        cyc(0, 0, 12'h000, '0, "R12 final idle");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule